// File: doc/BRIEF.md
# Video DRAM Fetch Sequencer with Refresh Collision

This block generates the strobe and address sequence that a raster display controller issues to dynamic RAM shared with a CPU. An external pixel-clock phase counter divides time into eight-step slots. Each slot in the active area holds two fetch bursts. A burst presents the low video-address byte once on the low-address strobe. It then strobes the upper address bits twice: first for the pixel byte, then for the attribute byte. Only the upper bits differ between the two.

The block also reproduces what happens when a CPU refresh cycle lands inside a burst. The refresh cycle's memory request drives the low-address strobe. If the refresh arrives at the first burst's low-byte latch, the refresh address replaces the video low byte and the fetch reads the wrong cells ("snow"). If it arrives in the last step of the first burst, the low strobe is held across into the second burst. The second burst then reuses the first burst's low byte, so the fetch is duplicated. A timing-select input and a variant-select input decide whether the collision window is open. In banked mode, a corrupted fetch whose refresh page lies in the top memory window reads from an aliased bank. A collision flag and the substituted byte are brought out, so the corruption can be observed per slot.

Top module: `vid_fetch_seq`

## Requirements
- R1: During reset (rst_n low at a clock edge) every output is zero on the following cycle.
- R2: When `active` is low at an edge, neither strobe is asserted and every output is zero on the next cycle.
- R3: Outputs follow the phase sampled one edge earlier. Phase 2 and phase 5 give `lo_stb`. Phases 3, 4, 6 and 7 give `hi_stb`, with `is_attr` high on 4 and 7. Phases 0 and 1 give no strobe, and the two strobes are never high together.
- R4: With no collision, the address on a `lo_stb` cycle is `vid_addr[7:0]`: the value for the first burst is sampled at phase 2 and the value for the second at phase 5.
- R5: On a pixel high strobe, `dram_addr` is `{2'b00, vid_addr[13:8]}`. On an attribute strobe, it is `{2'b00, 4'b0110, vid_addr[12:11]}`.
- R6: A refresh request at phase 2 with the window open gives snow. In that case the low-strobe address, `sub_addr` and the latched first-burst low byte all equal `rfsh_addr`, and `snow` and `collide` are high.
- R7: A refresh request at phase 4 with the window open gives a duplicate. The phase-5 low strobe then carries the first burst's low byte instead of the new `vid_addr[7:0]`, and `dup`, `collide` and `sub_addr` (set to that byte) mark it.
- R8: The collision window is open when `banked_mode` or `late_timing` is high, and closed when both are low. Refresh requests at any other phase never cause a collision.
- R9: `bank_out` is zero in non-banked mode and `screen_bank` in banked mode. One case overrides this for the three strobes of the first burst: when a banked-mode snow occurs with `rfsh_hi >= 8'hC0`, the bank is `page_sel & 3'b101`. `bank_out` is zero on cycles without a strobe.
- R10: `collide` equals `snow` OR `dup`, and `snow` and `dup` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase | input | 3 | Pixel-clock phase within the slot |
| active | input | 1 | Display area is active |
| vid_addr | input | 14 | Video address counter |
| rfsh_req | input | 1 | CPU refresh cycle is driving the memory request |
| rfsh_addr | input | 8 | Refresh address low byte |
| rfsh_hi | input | 8 | Refresh address high byte (page pointer) |
| late_timing | input | 1 | Late collision-timing configuration |
| banked_mode | input | 1 | Banked-memory variant |
| screen_bank | input | 3 | Bank holding the displayed screen |
| page_sel | input | 3 | Page currently selected into the top window |
| dram_addr | output | 8 | Multiplexed DRAM address |
| lo_stb | output | 1 | Low-address strobe |
| hi_stb | output | 1 | High-address strobe |
| is_attr | output | 1 | Current high strobe fetches an attribute byte |
| bank_out | output | 3 | Bank the fetch reads from |
| collide | output | 1 | A refresh collision changed this fetch |
| snow | output | 1 | Low byte replaced by the refresh address |
| dup | output | 1 | Second burst reused the first burst's low byte |
| sub_addr | output | 8 | Substituted low byte during a collision |

## Verification
The hardest case to reach is the duplicate fetch. The refresh must land exactly on phase 4, in a mode where the window is open, and the two bursts of the slot must carry different low bytes, or the reuse cannot be seen. Each directed slot walks the phase counter through all eight steps. It gives the second burst a low byte different from the first and raises the refresh request on one chosen phase only. The aliased-bank case is reached the same way by combining banked mode, a phase-2 refresh and a refresh page at or above the top window.

// File: rtl/vfs_pkg.sv
// Shared widths, constants and slot encoding for the video fetch sequencer.
package vfs_pkg;
    localparam int VA_W   = 14;
    localparam int LO_W   = 8;
    localparam int HI_W   = VA_W - LO_W;
    localparam int BANK_W = 3;
    localparam int PH_W   = 3;

    localparam logic [BANK_W-1:0] ALIAS_MASK = 3'b101;
    localparam logic [LO_W-1:0]   UPPER_WIN  = 8'hC0;
    localparam logic [3:0]        ATTR_BASE  = 4'b0110;

    localparam logic [PH_W-1:0] PH_LO_A  = 3'd2;
    localparam logic [PH_W-1:0] PH_PIX_A = 3'd3;
    localparam logic [PH_W-1:0] PH_ATR_A = 3'd4;
    localparam logic [PH_W-1:0] PH_LO_B  = 3'd5;
    localparam logic [PH_W-1:0] PH_PIX_B = 3'd6;
    localparam logic [PH_W-1:0] PH_ATR_B = 3'd7;

    typedef enum logic [2:0] {
        S_IDLE, S_LO_A, S_PIX_A, S_ATR_A, S_LO_B, S_PIX_B, S_ATR_B
    } slot_e;
endpackage

// File: rtl/vfs_slot_decode.sv
// Maps the pixel-clock phase onto a fetch slot step.
// Assumes the phase counter is driven externally and wraps at 8.
module vfs_slot_decode
    import vfs_pkg::*;
(
    input  logic [PH_W-1:0] phase,
    input  logic            active,
    output slot_e           slot
);
    // Decode the step; outside the active area everything is idle.
    always_comb begin
        slot = S_IDLE;
        if (active) begin
            case (phase)
                PH_LO_A:  slot = S_LO_A;
                PH_PIX_A: slot = S_PIX_A;
                PH_ATR_A: slot = S_ATR_A;
                PH_LO_B:  slot = S_LO_B;
                PH_PIX_B: slot = S_PIX_B;
                PH_ATR_B: slot = S_ATR_B;
                default:  slot = S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vfs_collide.sv
// Detects refresh cycles that land in a collision step of the burst.
// Assumes rfsh_req is high only on the phase the refresh request occupies.
module vfs_collide
    import vfs_pkg::*;
(
    input  slot_e           slot,
    input  logic            rfsh_req,
    input  logic [LO_W-1:0] rfsh_hi,
    input  logic            late_timing,
    input  logic            banked_mode,
    output logic            snow_hit,
    output logic            dup_hit,
    output logic            alias_hit
);
    logic win_open;

    // Window: banked variant always collides, non-banked only in late timing.
    always_comb begin
        win_open  = banked_mode | late_timing;
        snow_hit  = rfsh_req & win_open & (slot == S_LO_A);
        dup_hit   = rfsh_req & win_open & (slot == S_ATR_A);
        alias_hit = snow_hit & banked_mode & (rfsh_hi >= UPPER_WIN);
    end
endmodule

// File: rtl/vfs_out_stage.sv
// Registers the DRAM address, strobes, bank and collision flags per step.
// Holds the first burst's low byte and the pending-duplicate state.
module vfs_out_stage
    import vfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             slot,
    input  logic [VA_W-1:0]   vid_addr,
    input  logic [LO_W-1:0]   rfsh_addr,
    input  logic              banked_mode,
    input  logic [BANK_W-1:0] screen_bank,
    input  logic [BANK_W-1:0] page_sel,
    input  logic              snow_hit,
    input  logic              dup_hit,
    input  logic              alias_hit,
    output logic [LO_W-1:0]   dram_addr,
    output logic              lo_stb,
    output logic              hi_stb,
    output logic              is_attr,
    output logic [BANK_W-1:0] bank_out,
    output logic              collide,
    output logic              snow,
    output logic              dup,
    output logic [LO_W-1:0]   sub_addr
);
    logic [LO_W-1:0]   lo_a_q;
    logic              dup_pend_q;
    logic              alias_q;
    logic [BANK_W-1:0] base_bank;
    logic [BANK_W-1:0] alias_bank;
    logic [HI_W-1:0]   attr_hi;

    // Derive the default bank, the aliased bank and the attribute page.
    always_comb begin
        base_bank  = banked_mode ? screen_bank : '0;
        alias_bank = page_sel & ALIAS_MASK;
        attr_hi    = {ATTR_BASE, vid_addr[VA_W-2:VA_W-3]};
    end

    // Sequence the outputs for each slot step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_addr  <= '0;
            lo_stb     <= 1'b0;
            hi_stb     <= 1'b0;
            is_attr    <= 1'b0;
            bank_out   <= '0;
            collide    <= 1'b0;
            snow       <= 1'b0;
            dup        <= 1'b0;
            sub_addr   <= '0;
            lo_a_q     <= '0;
            dup_pend_q <= 1'b0;
            alias_q    <= 1'b0;
        end else begin
            dram_addr <= '0;
            lo_stb    <= 1'b0;
            hi_stb    <= 1'b0;
            is_attr   <= 1'b0;
            bank_out  <= '0;
            collide   <= 1'b0;
            snow      <= 1'b0;
            dup       <= 1'b0;
            sub_addr  <= '0;
            case (slot)
                S_LO_A: begin
                    lo_stb     <= 1'b1;
                    dram_addr  <= snow_hit ? rfsh_addr : vid_addr[LO_W-1:0];
                    lo_a_q     <= snow_hit ? rfsh_addr : vid_addr[LO_W-1:0];
                    snow       <= snow_hit;
                    collide    <= snow_hit;
                    sub_addr   <= snow_hit ? rfsh_addr : '0;
                    alias_q    <= alias_hit;
                    bank_out   <= alias_hit ? alias_bank : base_bank;
                    dup_pend_q <= 1'b0;
                end
                S_PIX_A: begin
                    hi_stb    <= 1'b1;
                    dram_addr <= {{(LO_W-HI_W){1'b0}}, vid_addr[VA_W-1:LO_W]};
                    bank_out  <= alias_q ? alias_bank : base_bank;
                end
                S_ATR_A: begin
                    hi_stb     <= 1'b1;
                    is_attr    <= 1'b1;
                    dram_addr  <= {{(LO_W-HI_W){1'b0}}, attr_hi};
                    bank_out   <= alias_q ? alias_bank : base_bank;
                    dup_pend_q <= dup_hit;
                end
                S_LO_B: begin
                    lo_stb     <= 1'b1;
                    dram_addr  <= dup_pend_q ? lo_a_q : vid_addr[LO_W-1:0];
                    dup        <= dup_pend_q;
                    collide    <= dup_pend_q;
                    sub_addr   <= dup_pend_q ? lo_a_q : '0;
                    bank_out   <= base_bank;
                    dup_pend_q <= 1'b0;
                    alias_q    <= 1'b0;
                end
                S_PIX_B: begin
                    hi_stb    <= 1'b1;
                    dram_addr <= {{(LO_W-HI_W){1'b0}}, vid_addr[VA_W-1:LO_W]};
                    bank_out  <= base_bank;
                end
                S_ATR_B: begin
                    hi_stb    <= 1'b1;
                    is_attr   <= 1'b1;
                    dram_addr <= {{(LO_W-HI_W){1'b0}}, attr_hi};
                    bank_out  <= base_bank;
                end
                default: begin
                    dup_pend_q <= 1'b0;
                    alias_q    <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/vid_fetch_seq.sv
// Top of the video DRAM fetch sequencer with refresh-collision modelling.
// Assumes phase advances once per pixel clock and inputs are synchronous.
module vid_fetch_seq
    import vfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase,
    input  logic              active,
    input  logic [VA_W-1:0]   vid_addr,
    input  logic              rfsh_req,
    input  logic [LO_W-1:0]   rfsh_addr,
    input  logic [LO_W-1:0]   rfsh_hi,
    input  logic              late_timing,
    input  logic              banked_mode,
    input  logic [BANK_W-1:0] screen_bank,
    input  logic [BANK_W-1:0] page_sel,
    output logic [LO_W-1:0]   dram_addr,
    output logic              lo_stb,
    output logic              hi_stb,
    output logic              is_attr,
    output logic [BANK_W-1:0] bank_out,
    output logic              collide,
    output logic              snow,
    output logic              dup,
    output logic [LO_W-1:0]   sub_addr
);
    slot_e slot;
    logic  snow_hit, dup_hit, alias_hit;

    vfs_slot_decode dec_i (
        .phase (phase),
        .active(active),
        .slot  (slot)
    );

    vfs_collide col_i (
        .slot       (slot),
        .rfsh_req   (rfsh_req),
        .rfsh_hi    (rfsh_hi),
        .late_timing(late_timing),
        .banked_mode(banked_mode),
        .snow_hit   (snow_hit),
        .dup_hit    (dup_hit),
        .alias_hit  (alias_hit)
    );

    vfs_out_stage out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot       (slot),
        .vid_addr   (vid_addr),
        .rfsh_addr  (rfsh_addr),
        .banked_mode(banked_mode),
        .screen_bank(screen_bank),
        .page_sel   (page_sel),
        .snow_hit   (snow_hit),
        .dup_hit    (dup_hit),
        .alias_hit  (alias_hit),
        .dram_addr  (dram_addr),
        .lo_stb     (lo_stb),
        .hi_stb     (hi_stb),
        .is_attr    (is_attr),
        .bank_out   (bank_out),
        .collide    (collide),
        .snow       (snow),
        .dup        (dup),
        .sub_addr   (sub_addr)
    );
endmodule

// File: rtl/vfs_checker.sv
// Temporal checks on the fetch sequencer ports, bound to the top module.
module vfs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        active,
    input logic [13:0] vid_addr,
    input logic [7:0]  rfsh_addr,
    input logic        late_timing,
    input logic        banked_mode,
    input logic [7:0]  dram_addr,
    input logic        lo_stb,
    input logic        hi_stb,
    input logic        is_attr,
    input logic        collide,
    input logic        snow,
    input logic        dup,
    input logic [7:0]  sub_addr
);
    logic past_ok;
    logic clk_seen;

    // Mark that one edge has passed since reset release, so $past is valid.
    always_ff @(posedge clk) begin
        clk_seen <= 1'b1;
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        (clk_seen === 1'b1) && $past(!rst_n) |-> !lo_stb && !hi_stb && !collide);

    p_quiet_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(active) |-> !lo_stb && !hi_stb);

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_stb && hi_stb));

    p_lo_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && lo_stb && !collide |-> dram_addr == $past(vid_addr[7:0]));

    p_pix_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && hi_stb && !is_attr |-> dram_addr == {2'b00, $past(vid_addr[13:8])});

    p_snow_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && snow |-> lo_stb && dram_addr == $past(rfsh_addr) && sub_addr == dram_addr);

    p_dup_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dup |-> lo_stb && dram_addr == sub_addr);

    p_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(banked_mode) && !$past(late_timing) |-> !collide);

    p_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({snow, dup}) && (collide == (snow || dup)));
endmodule

bind vid_fetch_seq vfs_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .vid_addr   (vid_addr),
    .rfsh_addr  (rfsh_addr),
    .late_timing(late_timing),
    .banked_mode(banked_mode),
    .dram_addr  (dram_addr),
    .lo_stb     (lo_stb),
    .hi_stb     (hi_stb),
    .is_attr    (is_attr),
    .collide    (collide),
    .snow       (snow),
    .dup        (dup),
    .sub_addr   (sub_addr)
);

// File: tb/vid_fetch_seq_tb_top.sv
// Directed bench: each task runs one slot scenario and checks every step.
module vid_fetch_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  phase = '0;
    logic        active = 1'b0;
    logic [13:0] vid_addr = '0;
    logic        rfsh_req = 1'b0;
    logic [7:0]  rfsh_addr = '0;
    logic [7:0]  rfsh_hi = '0;
    logic        late_timing = 1'b0;
    logic        banked_mode = 1'b0;
    logic [2:0]  screen_bank = '0;
    logic [2:0]  page_sel = '0;
    logic [7:0]  dram_addr;
    logic        lo_stb, hi_stb, is_attr, collide, snow, dup;
    logic [2:0]  bank_out;
    logic [7:0]  sub_addr;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    vid_fetch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .phase(phase), .active(active),
        .vid_addr(vid_addr), .rfsh_req(rfsh_req), .rfsh_addr(rfsh_addr),
        .rfsh_hi(rfsh_hi), .late_timing(late_timing), .banked_mode(banked_mode),
        .screen_bank(screen_bank), .page_sel(page_sel), .dram_addr(dram_addr),
        .lo_stb(lo_stb), .hi_stb(hi_stb), .is_attr(is_attr), .bank_out(bank_out),
        .collide(collide), .snow(snow), .dup(dup), .sub_addr(sub_addr)
    );

    // Packed view of all outputs: lo,hi,attr,addr,bank,collide,snow,dup,sub.
    function automatic logic [24:0] pack_out();
        return {lo_stb, hi_stb, is_attr, dram_addr, bank_out, collide, snow, dup, sub_addr};
    endfunction

    task automatic check(input string req, input logic [24:0] exp);
        checks++;
        if (pack_out() !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, pack_out(), exp);
        end
    endtask

    // Expected outputs for step p of a slot, from the requirements.
    function automatic logic [24:0] expect_step(
        input int p, input bit act, input int rph, input bit late, input bit bnk,
        input logic [13:0] va, input logic [13:0] vb, input logic [7:0] rfa,
        input logic [7:0] rfh, input logic [2:0] scr, input logic [2:0] pg);
        bit win, sn, dp, al;
        logic [7:0] lowa, addr, sub;
        logic [2:0] base, bank;
        bit lo, hi, at, col;
        win  = bnk || late;
        sn   = (rph == 2) && win;
        dp   = (rph == 4) && win;
        al   = sn && bnk && (rfh >= 8'hC0);
        lowa = sn ? rfa : va[7:0];
        base = bnk ? scr : 3'd0;
        lo = 0; hi = 0; at = 0; col = 0; addr = 0; sub = 0; bank = 0;
        if (act) begin
            case (p)
                2: begin lo = 1; addr = lowa; col = sn; sub = sn ? rfa : 8'h00;
                         bank = al ? (pg & 3'b101) : base; end
                3: begin hi = 1; addr = {2'b00, va[13:8]}; bank = al ? (pg & 3'b101) : base; end
                4: begin hi = 1; at = 1; addr = {2'b00, 4'b0110, va[12:11]};
                         bank = al ? (pg & 3'b101) : base; end
                5: begin lo = 1; addr = dp ? lowa : vb[7:0]; col = dp; sub = dp ? lowa : 8'h00;
                         bank = base; end
                6: begin hi = 1; addr = {2'b00, vb[13:8]}; bank = base; end
                7: begin hi = 1; at = 1; addr = {2'b00, 4'b0110, vb[12:11]}; bank = base; end
                default: ;
            endcase
        end
        return {lo, hi, at, addr, bank, col, (p == 2) && act && sn, (p == 5) && act && dp, sub};
    endfunction

    // Run one slot: drive each phase at a falling edge, check the step after it.
    task automatic run_slot(input string req, input bit act, input int rph,
        input bit late, input bit bnk, input logic [13:0] va, input logic [13:0] vb,
        input logic [7:0] rfa, input logic [7:0] rfh, input logic [2:0] scr,
        input logic [2:0] pg);
        active = act; late_timing = late; banked_mode = bnk;
        rfsh_addr = rfa; rfsh_hi = rfh; screen_bank = scr; page_sel = pg;
        for (int p = 0; p < 9; p++) begin
            @(negedge clk);
            if (p > 0)
                check(req, expect_step(p - 1, act, rph, late, bnk, va, vb, rfa, rfh, scr, pg));
            if (p < 8) begin
                phase    = 3'(p);
                vid_addr = (p < 5) ? va : vb;
                rfsh_req = (p == rph);
            end
        end
        rfsh_req = 1'b0;
        active = 1'b0;
        phase = '0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        // R1: outputs zero while and after reset is held
        rst_n = 1'b0; active = 1'b1; phase = 3'd2; vid_addr = 14'h1234;
        repeat (3) @(negedge clk);
        check("R1", 25'd0);
        active = 1'b0; phase = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_inactive();
        // R2: no strobes outside active area, even with a refresh at phase 2
        run_slot("R2", 0, 2, 1, 1, 14'h0ABC, 14'h0DEF, 8'h5A, 8'hFF, 3'd5, 3'd7);
    endtask

    task automatic t_clean();
        // R3 R4 R5: plain slot, distinct bytes per burst
        run_slot("R3_R4_R5", 1, -1, 0, 0, 14'h1A3C, 14'h2D71, 8'h00, 8'h00, 3'd0, 3'd0);
        run_slot("R5", 1, -1, 1, 0, 14'h3FFF, 14'h0800, 8'h00, 8'h00, 3'd0, 3'd0);
    endtask

    task automatic t_snow();
        // R6 R8: late timing, non-banked, refresh at phase 2
        run_slot("R6", 1, 2, 1, 0, 14'h0C21, 14'h0C22, 8'h9E, 8'h3F, 3'd0, 3'd0);
        // R8: early timing non-banked closes the window
        run_slot("R8", 1, 2, 0, 0, 14'h0C21, 14'h0C22, 8'h9E, 8'h3F, 3'd0, 3'd0);
        // R8: refresh at a non-collision phase has no effect
        run_slot("R8", 1, 6, 1, 1, 14'h1111, 14'h2222, 8'h77, 8'hFE, 3'd5, 3'd3);
    endtask

    task automatic t_dup();
        // R7 R8: banked early timing, refresh at phase 4
        run_slot("R7", 1, 4, 0, 1, 14'h0540, 14'h0541, 8'h33, 8'h3F, 3'd5, 3'd1);
        // R7 R8: non-banked late timing
        run_slot("R7", 1, 4, 1, 0, 14'h2A0F, 14'h2AF0, 8'h33, 8'h3F, 3'd0, 3'd0);
        // R8: non-banked early never duplicates
        run_slot("R8", 1, 4, 0, 0, 14'h2A0F, 14'h2AF0, 8'h33, 8'h3F, 3'd0, 3'd0);
    endtask

    task automatic t_bank();
        // R9: banked snow with refresh page in the top window aliases the bank
        run_slot("R9", 1, 2, 0, 1, 14'h0100, 14'h0101, 8'hC4, 8'hFE, 3'd5, 3'd7);
        // R9: same but page below the window keeps the screen bank
        run_slot("R9", 1, 2, 1, 1, 14'h0100, 14'h0101, 8'hC4, 8'h7E, 3'd7, 3'd3);
        // R9 R10: page 3 aliases to bank 1
        run_slot("R9_R10", 1, 2, 0, 1, 14'h3333, 14'h3334, 8'h01, 8'hC0, 3'd5, 3'd3);
    endtask

    initial begin
        t_reset();
        t_inactive();
        t_clean();
        t_snow();
        t_dup();
        t_bank();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule